// File: doc/BRIEF.md
# Compare and Conditional Branch Unit

This unit keeps a five-flag condition register and resolves short conditional branches against it. A compare strobe presents two register operands. The unit then records whether they were equal and how they are ordered. It records the signed order and the unsigned order separately, so one compare can serve both kinds of branch.

A branch strobe presents a 16-bit instruction word and the address of that instruction. The unit decodes the condition selector and tests it against the stored flags. One cycle later it reports the next program counter, a taken indication and an illegal-instruction indication. The register file, the fetch path and memory are outside the block. Operands and instruction words arrive already fetched.

Top module: `cmpbr_unit`

## Requirements
- R1: A compare strobe loads the condition register on the following clock edge. The flag positions are: bit 0 signed-greater, bit 1 signed-less, bit 2 equal, bit 3 unsigned-greater, bit 4 unsigned-less.
- R2: When the two operands are equal, the register becomes 5'b00100. Only the equal flag is set and all four ordering flags are clear.
- R3: When the operands differ, the equal flag is clear. Exactly one of bits 1:0 is set, from the signed comparison. Exactly one of bits 4:3 is set, from the unsigned comparison, chosen independently of the signed result.
- R4: The condition register resets to 0 and holds its value in every cycle without a compare strobe.
- R5: A word on the branch strobe is a conditional branch only when bits 15 and 14 are both 1. Any other word gives taken 0, illegal 0 and next PC = current PC + 2.
- R6: The selector in bits 13:10 picks the tested flags. Selectors 0 to 9 test, in order: equal; not equal; signed-less; signed-greater; unsigned-less; unsigned-greater; signed-greater or equal; signed-less or equal; unsigned-greater or equal; unsigned-less or equal.
- R7: A taken branch gives next PC = current PC + 2 × (bits 9:0 sign-extended) + 2, modulo 2^32, with taken 1.
- R8: A branch with a valid selector whose condition fails gives taken 0 and next PC = current PC + 2.
- R9: Selectors 10 to 15 give illegal 1, taken 0 and next PC equal to the current PC.
- R10: Branch results appear one clock after the strobe. In a cycle without a branch strobe, taken and illegal return to 0 and the next PC holds. After reset all three outputs are 0.
- R11: When a compare and a branch are strobed in the same cycle, the branch tests the flags as they were before that compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_req | input | 1 | Compare strobe |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| br_req | input | 1 | Branch strobe |
| br_insn | input | 16 | Branch instruction word |
| cur_pc | input | 32 | Address of the branch instruction |
| cc_q | output | 5 | Condition register |
| br_taken | output | 1 | Branch was taken |
| pc_next | output | 32 | Resolved next program counter |
| ill_insn | output | 1 | Illegal selector seen |

## Verification
The following are checked on every cycle:
- the exclusive-equal rule and the one-per-pair ordering rule for the flags;
- the condition register holding its value without a compare strobe;
- the next PC for non-branch words, illegal selectors and failed conditions;
- the quiet outputs in cycles without a branch strobe.

Other behaviour can only be shown by the bench's scenarios, where a reference model predicts every output. This covers:
- the mapping of each of the ten selectors onto the flags;
- the taken target for positive, negative and zero offsets, including address wrap;
- operand pairs where the signed and unsigned orders disagree;
- compare-and-branch in the same cycle, where the old flags must win.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
   localparam int FLAG_W   = 5;
   localparam int F_GT     = 0;
   localparam int F_LT     = 1;
   localparam int F_EQ     = 2;
   localparam int F_GTU    = 3;
   localparam int F_LTU    = 4;

   localparam int INSN_W   = 16;
   localparam int SEL_LO   = 10;
   localparam int SEL_W    = 4;
   localparam int FORM_HI  = 15;
   localparam int FORM_LO  = 14;

   typedef enum logic [SEL_W-1:0] {
      SEL_EQ  = 4'd0,
      SEL_NE  = 4'd1,
      SEL_LT  = 4'd2,
      SEL_GT  = 4'd3,
      SEL_LTU = 4'd4,
      SEL_GTU = 4'd5,
      SEL_GE  = 4'd6,
      SEL_LE  = 4'd7,
      SEL_GEU = 4'd8,
      SEL_LEU = 4'd9
   } cond_sel_e;

   localparam int SEL_LAST = 9;
endpackage

// File: rtl/cmpbr_flags.sv
module cmpbr_flags
   import cmpbr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_req,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [FLAG_W-1:0] cc_q
);
   logic [FLAG_W-1:0] cc_d;
   logic              same;
   logic              s_gt;
   logic              u_gt;

   assign same = (opnd_a == opnd_b);
   assign s_gt = ($signed(opnd_a) > $signed(opnd_b));
   assign u_gt = (opnd_a > opnd_b);

   always_comb begin
      cc_d = '0;
      if (same) begin
         cc_d[F_EQ] = 1'b1;
      end else begin
         cc_d[F_GT]  = s_gt;
         cc_d[F_LT]  = ~s_gt;
         cc_d[F_GTU] = u_gt;
         cc_d[F_LTU] = ~u_gt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cc_q <= '0;
      else if (cmp_req)
         cc_q <= cc_d;
   end
endmodule

// File: rtl/cmpbr_cond.sv
module cmpbr_cond
   import cmpbr_pkg::*;
(
   input  logic [FLAG_W-1:0] cc,
   input  logic [SEL_W-1:0]  sel,
   output logic              hit,
   output logic              bad
);
   always_comb begin
      hit = 1'b0;
      bad = 1'b0;
      case (sel)
         SEL_EQ:  hit = cc[F_EQ];
         SEL_NE:  hit = ~cc[F_EQ];
         SEL_LT:  hit = cc[F_LT];
         SEL_GT:  hit = cc[F_GT];
         SEL_LTU: hit = cc[F_LTU];
         SEL_GTU: hit = cc[F_GTU];
         SEL_GE:  hit = cc[F_GT]  | cc[F_EQ];
         SEL_LE:  hit = cc[F_LT]  | cc[F_EQ];
         SEL_GEU: hit = cc[F_GTU] | cc[F_EQ];
         SEL_LEU: hit = cc[F_LTU] | cc[F_EQ];
         default: bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/cmpbr_target.sv
module cmpbr_target
   import cmpbr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_req,
   input  logic              is_branch,
   input  logic              hit,
   input  logic              bad,
   input  logic [OFFS_W-1:0] offs,
   input  logic [ADDR_W-1:0] cur_pc,
   output logic [ADDR_W-1:0] pc_next,
   output logic              br_taken,
   output logic              ill_insn
);
   localparam int EXT_W = ADDR_W - OFFS_W - 1;

   logic [ADDR_W-1:0] disp;
   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] jmp_pc;
   logic [ADDR_W-1:0] pc_d;
   logic              tk_d;
   logic              il_d;

   generate
      if (EXT_W > 0) begin : g_sext
         assign disp = {{EXT_W{offs[OFFS_W-1]}}, offs, 1'b0};
      end else begin : g_trunc
         assign disp = {offs[ADDR_W-2:0], 1'b0};
      end
   endgenerate

   assign seq_pc = cur_pc + ADDR_W'(2);
   assign jmp_pc = seq_pc + disp;

   always_comb begin
      pc_d = pc_next;
      tk_d = 1'b0;
      il_d = 1'b0;
      if (br_req) begin
         if (!is_branch) begin
            pc_d = seq_pc;
         end else if (bad) begin
            pc_d = cur_pc;
            il_d = 1'b1;
         end else if (hit) begin
            pc_d = jmp_pc;
            tk_d = 1'b1;
         end else begin
            pc_d = seq_pc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_next  <= '0;
         br_taken <= 1'b0;
         ill_insn <= 1'b0;
      end else begin
         pc_next  <= pc_d;
         br_taken <= tk_d;
         ill_insn <= il_d;
      end
   end
endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
   import cmpbr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_req,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              br_req,
   input  logic [INSN_W-1:0] br_insn,
   input  logic [ADDR_W-1:0] cur_pc,
   output logic [FLAG_W-1:0] cc_q,
   output logic              br_taken,
   output logic [ADDR_W-1:0] pc_next,
   output logic              ill_insn
);
   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("cmpbr_unit: DATA_W must be at least 2");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("cmpbr_unit: ADDR_W must be at least 4");
      end
      if (OFFS_W < 1 || OFFS_W > SEL_LO) begin : g_bad_offs
         $error("cmpbr_unit: OFFS_W must fit below the selector field");
      end
   endgenerate

   logic              is_branch;
   logic              hit;
   logic              bad;
   logic [SEL_W-1:0]  sel;

   assign is_branch = br_insn[FORM_HI] & br_insn[FORM_LO];
   assign sel       = br_insn[SEL_LO +: SEL_W];

   cmpbr_flags #(.DATA_W(DATA_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_req (cmp_req),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .cc_q    (cc_q)
   );

   cmpbr_cond u_cond (
      .cc  (cc_q),
      .sel (sel),
      .hit (hit),
      .bad (bad)
   );

   cmpbr_target #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_target (
      .clk       (clk),
      .rst_n     (rst_n),
      .br_req    (br_req),
      .is_branch (is_branch),
      .hit       (hit),
      .bad       (bad),
      .offs      (br_insn[OFFS_W-1:0]),
      .cur_pc    (cur_pc),
      .pc_next   (pc_next),
      .br_taken  (br_taken),
      .ill_insn  (ill_insn)
   );
endmodule

// File: rtl/cmpbr_unit_chk.sv
module cmpbr_unit_chk
   import cmpbr_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmp_req,
   input logic              br_req,
   input logic [INSN_W-1:0] br_insn,
   input logic [ADDR_W-1:0] cur_pc,
   input logic [FLAG_W-1:0] cc_q,
   input logic              br_taken,
   input logic [ADDR_W-1:0] pc_next,
   input logic              ill_insn
);
   logic fmt_ok;
   logic sel_bad;

   assign fmt_ok  = br_insn[FORM_HI] & br_insn[FORM_LO];
   assign sel_bad = (br_insn[SEL_LO +: SEL_W] > SEL_W'(SEL_LAST));

   assert_cmp_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req |=> (cc_q != '0));

   assert_eq_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cc_q[F_EQ] |-> (cc_q[F_GT] == 1'b0 && cc_q[F_LT] == 1'b0 &&
                      cc_q[F_GTU] == 1'b0 && cc_q[F_LTU] == 1'b0));

   assert_order_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_q != '0 && !cc_q[F_EQ]) |->
         ($countones({cc_q[F_LT], cc_q[F_GT]}) == 1 &&
          $countones({cc_q[F_LTU], cc_q[F_GTU]}) == 1));

   assert_cc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_req |=> $stable(cc_q));

   assert_nonbranch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (br_req && !fmt_ok) |=>
         (!br_taken && !ill_insn && pc_next == $past(cur_pc) + ADDR_W'(2)));

   assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (br_req && fmt_ok && !sel_bad) |=>
         (!ill_insn && (br_taken || pc_next == $past(cur_pc) + ADDR_W'(2))));

   assert_illegal_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (br_req && fmt_ok && sel_bad) |=>
         (ill_insn && !br_taken && pc_next == $past(cur_pc)));

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !br_req |=> (!br_taken && !ill_insn && $stable(pc_next)));
endmodule

bind cmpbr_unit cmpbr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmp_req  (cmp_req),
   .br_req   (br_req),
   .br_insn  (br_insn),
   .cur_pc   (cur_pc),
   .cc_q     (cc_q),
   .br_taken (br_taken),
   .pc_next  (pc_next),
   .ill_insn (ill_insn)
);

// File: tb/cmpbr_unit_test.sv
module cmpbr_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_req = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        br_req = 1'b0;
   logic [15:0] br_insn = '0;
   logic [31:0] cur_pc = '0;
   logic [4:0]  cc_q;
   logic        br_taken;
   logic [31:0] pc_next;
   logic        ill_insn;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [4:0]  m_cc = '0;
   logic        m_tk = 1'b0;
   logic [31:0] m_pc = '0;
   logic        m_il = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmpbr_unit uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_req  (cmp_req),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .br_req   (br_req),
      .br_insn  (br_insn),
      .cur_pc   (cur_pc),
      .cc_q     (cc_q),
      .br_taken (br_taken),
      .pc_next  (pc_next),
      .ill_insn (ill_insn)
   );

   // Flag layout: bit0 signed-greater, bit1 signed-less, bit2 equal,
   // bit3 unsigned-greater, bit4 unsigned-less.
   function automatic logic [4:0] ref_cmp(input logic [31:0] a, input logic [31:0] b);
      logic [4:0] r = 5'd0;
      if (a == b) return 5'b00100;
      if ($signed(a) < $signed(b)) r[1] = 1'b1; else r[0] = 1'b1;
      if (a < b) r[4] = 1'b1; else r[3] = 1'b1;
      return r;
   endfunction

   function automatic logic ref_test(input logic [4:0] f, input int code);
      case (code)
         0: return f[2];
         1: return !f[2];
         2: return f[1];
         3: return f[0];
         4: return f[4];
         5: return f[3];
         6: return f[0] || f[2];
         7: return f[1] || f[2];
         8: return f[3] || f[2];
         9: return f[4] || f[2];
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(tag, "cc_q", 32'(cc_q), 32'(m_cc));
      check(tag, "br_taken", 32'(br_taken), 32'(m_tk));
      check(tag, "pc_next", pc_next, m_pc);
      check(tag, "ill_insn", 32'(ill_insn), 32'(m_il));
   endtask

   task automatic step(input string tag, input logic c, input logic [31:0] a,
                       input logic [31:0] b, input logic br, input logic [15:0] w,
                       input logic [31:0] pc);
      logic [4:0]  e_cc;
      logic        e_tk;
      logic [31:0] e_pc;
      logic        e_il;
      int          code;
      int          off;
      @(negedge clk);
      cmp_req = c; opnd_a = a; opnd_b = b;
      br_req = br; br_insn = w; cur_pc = pc;
      e_cc = c ? ref_cmp(a, b) : m_cc;
      e_tk = 1'b0; e_il = 1'b0; e_pc = m_pc;
      if (br) begin
         if (w[15] && w[14]) begin
            code = int'(w[13:10]);
            off  = int'(w[9:0]);
            if (off >= 512) off = off - 1024;
            if (code > 9) begin
               e_il = 1'b1; e_pc = pc;
            end else if (ref_test(m_cc, code)) begin
               e_tk = 1'b1; e_pc = pc + 32'(off * 2) + 32'd2;
            end else begin
               e_pc = pc + 32'd2;
            end
         end else begin
            e_pc = pc + 32'd2;
         end
      end
      @(posedge clk);
      #1;
      m_cc = e_cc; m_tk = e_tk; m_pc = e_pc; m_il = e_il;
      compare_all(tag);
   endtask

   function automatic logic [15:0] bw(input int code, input int off10);
      return {2'b11, 4'(code), 10'(off10)};
   endfunction

   task automatic sweep(input string tag, input logic [31:0] pc, input int off10);
      for (int k = 0; k < 16; k++) begin
         step((k > 9) ? "R9" : tag, 1'b0, 32'h0, 32'h0, 1'b1, bw(k, off10), pc);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      compare_all("R4_R10_reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R4: operands change without a strobe
      step("R4", 1'b0, 32'h5, 32'h3, 1'b0, 16'h0, 32'h0);
      step("R4", 1'b0, 32'hFFFF_FFFF, 32'h1, 1'b0, 16'h0, 32'h0);

      // R2: equal operands
      step("R2", 1'b1, 32'h1234_5678, 32'h1234_5678, 1'b0, 16'h0, 32'h0);
      sweep("R6", 32'h0000_1000, 10);

      // R3: signed and unsigned orders agree (greater)
      step("R3", 1'b1, 32'd5, 32'd3, 1'b0, 16'h0, 32'h0);
      sweep("R6", 32'h0000_2000, 12'h3FF);

      // R3: signed less, unsigned greater
      step("R3", 1'b1, 32'hFFFF_FFFF, 32'h1, 1'b0, 16'h0, 32'h0);
      sweep("R6", 32'h0000_3000, 12'h1FF);

      // R3: signed less, unsigned greater at the sign boundary
      step("R3", 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 16'h0, 32'h0);
      sweep("R7", 32'h0000_4000, 12'h200);

      // R3: signed greater, unsigned less
      step("R1", 1'b1, 32'h1, 32'hFFFF_FFFE, 1'b0, 16'h0, 32'h0);
      sweep("R8", 32'h0000_5000, 0);

      // R3: both less
      step("R3", 1'b1, 32'd2, 32'd9, 1'b0, 16'h0, 32'h0);
      sweep("R6", 32'h0000_6000, 3);

      // R7: address wrap past the top
      step("R7", 1'b0, 32'h0, 32'h0, 1'b1, bw(1, 0), 32'hFFFF_FFFE);
      step("R7", 1'b0, 32'h0, 32'h0, 1'b1, bw(1, 12'h3FE), 32'h0000_0002);

      // R10: idle cycles hold the PC and clear the pulses
      step("R10", 1'b0, 32'h0, 32'h0, 1'b0, bw(1, 4), 32'h0000_7000);
      step("R10", 1'b0, 32'h0, 32'h0, 1'b0, bw(12, 4), 32'h0000_7000);

      // R5: words outside the branch form
      step("R5", 1'b0, 32'h0, 32'h0, 1'b1, 16'h8000 | 16'h0C00, 32'h0000_8000);
      step("R5", 1'b0, 32'h0, 32'h0, 1'b1, 16'h7C05, 32'h0000_8100);
      step("R5", 1'b0, 32'h0, 32'h0, 1'b1, 16'h0000, 32'h0000_8200);

      // R11: compare and branch together use the old flags
      step("R11", 1'b1, 32'd7, 32'd7, 1'b1, bw(0, 8), 32'h0000_9000);
      step("R11", 1'b1, 32'd1, 32'd7, 1'b1, bw(0, 8), 32'h0000_9100);
      step("R11", 1'b0, 32'd0, 32'd0, 1'b1, bw(2, 8), 32'h0000_9200);

      // R9 followed by a quiet cycle
      step("R9", 1'b0, 32'h0, 32'h0, 1'b1, bw(15, 1), 32'h0000_A000);
      step("R10", 1'b0, 32'h0, 32'h0, 1'b0, 16'h0, 32'h0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule